// File: doc/BRIEF.md
# Accumulator ALU with Four-Flag Status

This block is the arithmetic and logic unit of a small 8-bit accumulator processor. Each clock it takes an operation code, the accumulator byte, a second operand byte and the current status byte, and one cycle later it presents the result byte, a strobe saying whether the result should be written back to the accumulator, and the new status byte. The decoder, the register file and the operand fetch sit outside the block. The caller only has to route the returned byte and strobe to the accumulator and the returned status byte to the flag register.

The status byte holds four flags in its upper nibble: zero (Z), subtract (N), half-carry (H) and carry (C). Each operation has its own rule for each flag: set from the result, forced to a fixed value, or passed through unchanged. The operations are add and subtract with and without the incoming carry, compare, the three bitwise operations, complement, and an extended group of eight rotate, shift and nibble-exchange operations. The extended group is selected by bit 4 of the operation code.

Top module: `acc_alu8`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `res_o`=0, `res_we_o`=0 and `flag_o`=0. In every other case the outputs reflect the inputs sampled at the preceding rising edge.
- R2: Opcodes 0 (add) and 1 (add with carry) write the low byte of A+B (plus incoming C for opcode 1). C is bit 8 of that sum. H is set when the low-nibble sum, carry included for opcode 1, exceeds 15. N=0, and Z is set when the result byte is zero.
- R3: Opcodes 2 (subtract) and 3 (subtract with borrow) write A-B (minus incoming C for opcode 3) modulo 256. N=1. C is set when B (plus incoming C for opcode 3) exceeds A. H is set when the low nibble of B (plus incoming C for opcode 3) exceeds the low nibble of A. Z is set from the result.
- R4: Opcode 7 (compare) sets Z, N, H and C exactly as opcode 2 does, holds `res_we_o` at 0 and returns A on `res_o`.
- R5: Opcodes 4 (AND), 5 (XOR) and 6 (OR) write the bitwise result and set Z from it, with N=0 and C=0. H=1 for AND and H=0 for XOR and OR.
- R6: Opcode 8 (complement) writes the bitwise inverse of A, forces N=1 and H=1, and passes the incoming Z and C through unchanged.
- R7: Opcodes 16 and 17 rotate A circularly, left and right respectively. The bit leaving the byte enters the vacated end and is also copied into C.
- R8: Opcodes 18 and 19 rotate A through the carry, left and right respectively. The incoming C enters the vacated end and the bit leaving the byte becomes the new C.
- R9: Opcode 20 shifts left with 0 fill and takes C from bit 7. Opcode 21 shifts right keeping bit 7 and takes C from bit 0. Opcode 23 shifts right with 0 fill and takes C from bit 0.
- R10: Opcode 22 exchanges the two nibbles of A, sets Z when A is zero and clears C.
- R11: Every operation with opcode 16 to 23 writes its result, clears N and H, and sets Z when the result byte is zero.
- R12: The status byte carries Z in bit 7, N in bit 6, H in bit 5 and C in bit 4. Bits 3 to 0 of `flag_o` are always 0, whatever `flag_i` holds.
- R13: Any opcode not listed above leaves `res_we_o` at 0, returns A on `res_o`, and returns the upper nibble of `flag_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator operand A |
| opnd_i | input | 8 | Second operand B |
| flag_i | input | 8 | Current status byte (Z,N,H,C in bits 7..4) |
| res_o | output | 8 | Result byte |
| res_we_o | output | 1 | Result should be written to the accumulator |
| flag_o | output | 8 | Updated status byte |

## Verification
Every result, strobe and status byte is due exactly one rising edge after the inputs that produce it are sampled. No operation takes longer, so one expected item belongs to each driven cycle. The driver applies a new input set at every falling edge and queues the expected outputs. The monitor reads the outputs 2 ns after each following rising edge and pops exactly one item per edge, so a result that arrives a cycle early or late is compared against the wrong entry and reported. The add and subtract opcodes are swept over every A and B pair. Compare and the carry-using forms get a stride sweep over A with every B, and every single-operand opcode gets every A with both carry values.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW    = 8;
    localparam int NW    = DW / 2;
    localparam int OPW   = 5;
    localparam int FZ    = 7;
    localparam int FN    = 6;
    localparam int FH    = 5;
    localparam int FC    = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_AND  = 5'd4,
        OP_XOR  = 5'd5,
        OP_OR   = 5'd6,
        OP_CMP  = 5'd7,
        OP_INV  = 5'd8,
        OP_ROLC = 5'd16,
        OP_RORC = 5'd17,
        OP_ROLT = 5'd18,
        OP_RORT = 5'd19,
        OP_SHLA = 5'd20,
        OP_SHRA = 5'd21,
        OP_NSWP = 5'd22,
        OP_SHRL = 5'd23
    } alu_op_e;

    // shifter sub-select, order follows the low three opcode bits
    typedef enum logic [2:0] {
        SH_ROLC = 3'd0,
        SH_RORC = 3'd1,
        SH_ROLT = 3'd2,
        SH_RORT = 3'd3,
        SH_SHLA = 3'd4,
        SH_SHRA = 3'd5,
        SH_NSWP = 3'd6,
        SH_SHRL = 3'd7
    } sh_sel_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          we;
        flags_t        fl;
    } alu_out_t;

    function automatic flags_t flags_from_byte(input logic [DW-1:0] b);
        flags_t f;
        f.z = b[FZ];
        f.n = b[FN];
        f.h = b[FH];
        f.c = b[FC];
        return f;
    endfunction

    function automatic logic [DW-1:0] flags_to_byte(input flags_t f);
        logic [DW-1:0] b;
        b     = '0;
        b[FZ] = f.z;
        b[FN] = f.n;
        b[FH] = f.h;
        b[FC] = f.c;
        return b;
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          sum_c,
    output logic          sum_h,
    output logic [DW-1:0] dif,
    output logic          dif_b,
    output logic          dif_hb
);
    localparam int XW = DW + 1;
    localparam int HW = NW + 1;

    logic [XW-1:0] s_w, d_w;
    logic [HW-1:0] s_n, d_n;

    always_comb begin
        s_w = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
        d_w = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
        s_n = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
        d_n = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, cin};
    end

    assign sum    = s_w[DW-1:0];
    assign sum_c  = s_w[DW];
    assign sum_h  = s_n[NW];
    assign dif    = d_w[DW-1:0];
    assign dif_b  = d_w[DW];
    assign dif_hb = d_n[NW];
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          z_in,
    input  logic          c_in,
    output logic [DW-1:0] res,
    output flags_t        fl
);
    always_comb begin
        res  = a;
        fl.z = z_in;
        fl.n = 1'b0;
        fl.h = 1'b0;
        fl.c = 1'b0;
        unique case (op)
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            OP_OR:   res = a | b;
            default: res = ~a;
        endcase
        if (op == OP_INV) begin
            fl.n = 1'b1;
            fl.h = 1'b1;
            fl.c = c_in;
        end else begin
            fl.z = (res == '0);
            fl.h = (op == OP_AND);
        end
    end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter
    import alu8_pkg::*;
(
    input  sh_sel_e       sel,
    input  logic [DW-1:0] a,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          cout
);
    logic [DW-1:0] swp;

    // nibble exchange built per bit
    for (genvar i = 0; i < DW; i++) begin : g_swp
        assign swp[i] = a[(i + NW) % DW];
    end

    always_comb begin
        unique case (sel)
            SH_ROLC: begin res = {a[DW-2:0], a[DW-1]}; cout = a[DW-1]; end
            SH_RORC: begin res = {a[0], a[DW-1:1]};    cout = a[0];    end
            SH_ROLT: begin res = {a[DW-2:0], cin};     cout = a[DW-1]; end
            SH_RORT: begin res = {cin, a[DW-1:1]};     cout = a[0];    end
            SH_SHLA: begin res = {a[DW-2:0], 1'b0};    cout = a[DW-1]; end
            SH_SHRA: begin res = {a[DW-1], a[DW-1:1]}; cout = a[0];    end
            SH_NSWP: begin res = swp;                  cout = 1'b0;    end
            default: begin res = {1'b0, a[DW-1:1]};    cout = a[0];    end
        endcase
    end
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
    import alu8_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] op_i,
    input  logic [DW-1:0]  acc_i,
    input  logic [DW-1:0]  opnd_i,
    input  logic [DW-1:0]  flag_i,
    output logic [DW-1:0]  res_o,
    output logic           res_we_o,
    output logic [DW-1:0]  flag_o
);
    alu_op_e  op;
    flags_t   fin;
    alu_out_t nxt, q;
    logic     unused_lo;

    assign op        = alu_op_e'(op_i);
    assign fin       = flags_from_byte(flag_i);
    assign unused_lo = ^flag_i[FC-1:0];

    logic          use_c;
    logic [DW-1:0] as_sum, as_dif;
    logic          as_c, as_h, as_b, as_hb;

    assign use_c = (op == OP_ADC) || (op == OP_SBC);

    alu8_addsub u_as (
        .a      (acc_i),
        .b      (opnd_i),
        .cin    (use_c & fin.c),
        .sum    (as_sum),
        .sum_c  (as_c),
        .sum_h  (as_h),
        .dif    (as_dif),
        .dif_b  (as_b),
        .dif_hb (as_hb)
    );

    logic [DW-1:0] bw_res;
    flags_t        bw_fl;

    alu8_bitwise u_bw (
        .op   (op),
        .a    (acc_i),
        .b    (opnd_i),
        .z_in (fin.z),
        .c_in (fin.c),
        .res  (bw_res),
        .fl   (bw_fl)
    );

    logic [DW-1:0] sh_res;
    logic          sh_c;

    alu8_shifter u_sh (
        .sel  (sh_sel_e'(op_i[2:0])),
        .a    (acc_i),
        .cin  (fin.c),
        .res  (sh_res),
        .cout (sh_c)
    );

    always_comb begin
        nxt.res = acc_i;
        nxt.we  = 1'b0;
        nxt.fl  = fin;
        unique case (op)
            OP_ADD, OP_ADC: begin
                nxt.res = as_sum;
                nxt.we  = 1'b1;
                nxt.fl  = '{z: (as_sum == '0), n: 1'b0, h: as_h, c: as_c};
            end
            OP_SUB, OP_SBC: begin
                nxt.res = as_dif;
                nxt.we  = 1'b1;
                nxt.fl  = '{z: (as_dif == '0), n: 1'b1, h: as_hb, c: as_b};
            end
            OP_CMP: begin
                nxt.fl  = '{z: (as_dif == '0), n: 1'b1, h: as_hb, c: as_b};
            end
            OP_AND, OP_XOR, OP_OR, OP_INV: begin
                nxt.res = bw_res;
                nxt.we  = 1'b1;
                nxt.fl  = bw_fl;
            end
            OP_ROLC, OP_RORC, OP_ROLT, OP_RORT,
            OP_SHLA, OP_SHRA, OP_NSWP, OP_SHRL: begin
                nxt.res = sh_res;
                nxt.we  = 1'b1;
                nxt.fl  = '{z: (sh_res == '0), n: 1'b0, h: 1'b0, c: sh_c};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

    assign res_o    = q.res;
    assign res_we_o = q.we;
    assign flag_o   = flags_to_byte(q.fl);
endmodule

// File: rtl/acc_alu8_chk.sv
module acc_alu8_chk (
    input logic       clk,
    input logic       rst,
    input logic [4:0] op_i,
    input logic [7:0] acc_i,
    input logic [7:0] flag_i,
    input logic [7:0] res_o,
    input logic       res_we_o,
    input logic [7:0] flag_o
);
    // R12
    flag_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        flag_o[3:0] == 4'b0000);

    // R4
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_i) == 5'd7) |-> (!res_we_o && res_o == $past(acc_i) && flag_o[6]));

    // R6
    inv_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_i) == 5'd8) |->
            (flag_o[6:5] == 2'b11 && flag_o[7] == $past(flag_i[7]) &&
             flag_o[4] == $past(flag_i[4]) && res_o == ~$past(acc_i)));

    // R3
    sub_n_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(op_i) == 5'd2 || $past(op_i) == 5'd3)) |-> (flag_o[6] && res_we_o));

    // R10
    nswap_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_i) == 5'd22) |->
            (res_o == {$past(acc_i[3:0]), $past(acc_i[7:4])} && !flag_o[4]));

    // R11
    shift_nh_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_i[4:3]) == 2'b10) |->
            (flag_o[6:5] == 2'b00 && res_we_o && flag_o[7] == (res_o == 8'h00)));

    // R13
    undef_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_i) > 5'd8 && $past(op_i) < 5'd16) |->
            (!res_we_o && res_o == $past(acc_i) && flag_o[7:4] == $past(flag_i[7:4])));
endmodule

bind acc_alu8 acc_alu8_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op_i),
    .acc_i    (acc_i),
    .flag_i   (flag_i),
    .res_o    (res_o),
    .res_we_o (res_we_o),
    .flag_o   (flag_o)
);

// File: tb/sim_acc_alu8.sv
module sim_acc_alu8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] op_i = '0;
    logic [7:0] acc_i = '0;
    logic [7:0] opnd_i = '0;
    logic [7:0] flag_i = '0;
    logic [7:0] res_o;
    logic       res_we_o;
    logic [7:0] flag_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    acc_alu8 u0 (
        .clk      (clk),
        .rst      (rst),
        .op_i     (op_i),
        .acc_i    (acc_i),
        .opnd_i   (opnd_i),
        .flag_i   (flag_i),
        .res_o    (res_o),
        .res_we_o (res_we_o),
        .flag_o   (flag_o)
    );

    typedef struct {
        logic [4:0]  op;
        logic [16:0] exp;
    } item_t;

    item_t pend[$];

    // independent reference: returns {we, res[7:0], status byte}
    function automatic logic [16:0] model(input logic [4:0] op, input logic [7:0] a8,
                                          input logic [7:0] b8, input logic [7:0] f8);
        int a = a8;
        int b = b8;
        int ci = f8[4];
        int k = 0;
        int r = a8;
        logic we = 1'b0;
        logic z = f8[7], n = f8[6], h = f8[5], c = f8[4];
        logic [7:0] rb;
        case (op)
            5'd0, 5'd1: begin
                k = (op == 5'd1) ? ci : 0;
                r = a + b + k;
                h = ((a % 16) + (b % 16) + k) > 15;
                c = r > 255;
                r = r % 256;
                n = 1'b0; z = (r == 0); we = 1'b1;
            end
            5'd2, 5'd3, 5'd7: begin
                k = (op == 5'd3) ? ci : 0;
                c = (b + k) > a;
                h = ((b % 16) + k) > (a % 16);
                r = (a - b - k + 512) % 256;
                n = 1'b1; z = (r == 0); we = (op != 5'd7);
                if (op == 5'd7) r = a;
            end
            5'd4: begin r = a & b; z = (r == 0); n = 0; h = 1; c = 0; we = 1; end
            5'd5: begin r = a ^ b; z = (r == 0); n = 0; h = 0; c = 0; we = 1; end
            5'd6: begin r = a | b; z = (r == 0); n = 0; h = 0; c = 0; we = 1; end
            5'd8: begin r = 255 - a; n = 1; h = 1; we = 1; end
            5'd16: begin r = (a * 2 + a / 128) % 256; c = (a / 128) != 0; end
            5'd17: begin r = a / 2 + (a % 2) * 128;   c = (a % 2) != 0; end
            5'd18: begin r = (a * 2 + ci) % 256;      c = (a / 128) != 0; end
            5'd19: begin r = a / 2 + ci * 128;        c = (a % 2) != 0; end
            5'd20: begin r = (a * 2) % 256;           c = (a / 128) != 0; end
            5'd21: begin r = a / 2 + (a / 128) * 128; c = (a % 2) != 0; end
            5'd22: begin r = (a % 16) * 16 + a / 16;  c = 1'b0; end
            5'd23: begin r = a / 2;                   c = (a % 2) != 0; end
            default: ;
        endcase
        if (op >= 5'd16 && op <= 5'd23) begin
            n = 1'b0; h = 1'b0; z = (r == 0); we = 1'b1;
        end
        rb = r[7:0];
        return {we, rb, z, n, h, c, 4'b0000};
    endfunction

    function automatic string tag_of(input logic [4:0] op);
        case (op)
            5'd0, 5'd1:                 return "R2";
            5'd2, 5'd3:                 return "R3";
            5'd7:                       return "R4";
            5'd4, 5'd5, 5'd6:           return "R5";
            5'd8:                       return "R6";
            5'd16, 5'd17:               return "R7";
            5'd18, 5'd19:               return "R8";
            5'd20, 5'd21, 5'd23:        return "R9";
            5'd22:                      return "R10";
            default:                    return "R13";
        endcase
    endfunction

    task automatic drive(input logic [4:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic [7:0] f);
        item_t it;
        @(negedge clk);
        op_i   = op;
        acc_i  = a;
        opnd_i = b;
        flag_i = f;
        it.op  = op;
        it.exp = model(op, a, b, f);
        pend.push_back(it);
    endtask

    // monitor: one item per rising edge, sampled 2 ns after it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (pend.size() > 0) begin
                item_t it;
                logic [16:0] got;
                it  = pend.pop_front();
                got = {res_we_o, res_o, flag_o};
                checks++;
                if (got != it.exp) begin
                    errors++;
                    $display("FAIL %s op=%0d got we=%b res=%02h fl=%02h exp we=%b res=%02h fl=%02h",
                             tag_of(it.op), it.op, got[16], got[15:8], got[7:0],
                             it.exp[16], it.exp[15:8], it.exp[7:0]);
                end
                // R12 low nibble of the status byte
                checks++;
                if (flag_o[3:0] != 4'h0) begin
                    errors++;
                    $display("FAIL R12 low flag bits got %h exp 0", flag_o[3:0]);
                end
                // R11 N and H clear for the extended group
                if (it.op[4:3] == 2'b10) begin
                    checks++;
                    if (flag_o[6:5] != 2'b00) begin
                        errors++;
                        $display("FAIL R11 op=%0d N,H got %b exp 00", it.op, flag_o[6:5]);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        for (int i = 0; i < 195000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset holds outputs at zero even with live inputs
        op_i = 5'd0; acc_i = 8'hFF; opnd_i = 8'h01; flag_i = 8'hFF;
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (res_o != 8'h00 || res_we_o != 1'b0 || flag_o != 8'h00) begin
            errors++;
            $display("FAIL R1 reset got we=%b res=%02h fl=%02h exp 0 00 00",
                     res_we_o, res_o, flag_o);
        end
        @(negedge clk);
        rst = 1'b0;

        // R2 / R3: full sweep of add and subtract
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                logic [7:0] f;
                f = {4'((a ^ b) & 15), 4'(a & 15)};
                drive(5'd0, 8'(a), 8'(b), f);
                drive(5'd2, 8'(a), 8'(b), f);
            end
        end

        // R2 R3 R4: carry forms and compare, stride over A
        for (int a = 0; a < 256; a += 17) begin
            for (int b = 0; b < 256; b++) begin
                drive(5'd1, 8'(a), 8'(b), {3'b000, 1'(b), 4'h0});
                drive(5'd3, 8'(a), 8'(b), {3'b101, 1'(b + 1), 4'h5});
                drive(5'd7, 8'(a), 8'(b), 8'hFF);
            end
        end
        // boundary carry-in cases (R2 R3)
        drive(5'd1, 8'hFF, 8'h00, 8'h10);
        drive(5'd1, 8'h0F, 8'h00, 8'h10);
        drive(5'd3, 8'h00, 8'hFF, 8'h10);
        drive(5'd3, 8'h10, 8'h0F, 8'h10);

        // R5 to R11: single-operand and bitwise ops, every A, both carries
        for (int a = 0; a < 256; a++) begin
            for (int cc = 0; cc < 2; cc++) begin
                logic [7:0] f;
                f = {1'(a >> 3), 1'(a >> 5), 1'(a >> 6), 1'(cc), 4'(a)};
                drive(5'd4, 8'(a), 8'(a * 7 + 3), f);
                drive(5'd5, 8'(a), 8'(a * 5 + cc), f);
                drive(5'd6, 8'(a), 8'(a * 3), f);
                drive(5'd8, 8'(a), 8'h00, f);
                for (int s = 16; s < 24; s++) drive(5'(s), 8'(a), 8'h00, f);
            end
        end

        // R13: opcodes outside the defined set
        for (int u = 9; u < 16; u++) drive(5'(u), 8'(u * 13), 8'h55, 8'hAF);
        for (int u = 24; u < 32; u++) drive(5'(u), 8'(u * 29), 8'hAA, 8'h5A);

        while (pend.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule